// File: doc/BRIEF.md
# ECC Error Capture Registers

This block sits beside the error detector of a two-channel DRAM controller. Each channel reports correctable and uncorrectable events together with the column, row, bank, rank and syndrome of the failing access. The block keeps one 64-bit log for each channel and one shared 16-bit status word. Software reads all of these over a simple register bus.

A log captures the first correctable error it sees. An uncorrectable error replaces a held correctable one, and a correctable error never displaces an uncorrectable one. Software acknowledges an error by writing ones to the status word. That write also releases the matching log flags, so each log can capture again.

A configuration input turns off the second channel. While it is set, that channel's events are ignored and its log reads as zero. A per-channel row index register gives the failing rank combined with the channel number.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero, except the channel 1 row index, which reads 4. In the status word (address 0), bit 0 is set by a correctable event and bit 1 by an uncorrectable event from any enabled channel. Bits 15:2 of the status word, and the upper 16 bits of that bus word, always read zero.
- R2: A bus write to address 0 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave the status unchanged. Writes to any other address change nothing.
- R3: Channel c's log is read as two words: bits 31:0 at address 1+2c and bits 63:32 at address 2+2c. The log layout is:
  - bits 63:48 column, bits 47:32 row, bits 31:29 bank, bits 28:27 rank, bits 23:16 syndrome;
  - bit 1 is the uncorrectable flag and bit 0 is the correctable flag;
  - all other bits are zero.
  Unmapped addresses (7 and above) read zero.
- R4: An empty log (both flags clear) captures a correctable event with bit 0 set. While a log holds a correctable error, a further correctable event leaves the log unchanged, but it still sets status bit 0.
- R5: An uncorrectable event replaces a log that is empty or holds a correctable error. The new log has bit 1 set and bit 0 clear. While the log holds an uncorrectable error, later events of either kind leave it unchanged. An event carrying both kinds counts as uncorrectable.
- R6: Clearing status bit 0 releases the correctable flag of every log, and clearing bit 1 releases the uncorrectable flag. A log left with no flag reads entirely zero.
- R7: If a clear write and a new event arrive in the same cycle, the event wins. The status bit stays set, and the log captures the new event as if it had been released just before.
- R8: While `single_chan` is 1, channel 1 events set no status bit and its log reads zero. After a clear write has released the flags, the next channel 1 event is captured normally.
- R9: The row index of channel c reads at address 5+c. Its value is the logged rank OR (c × 4), zero-extended.
- R10: Reads are combinational from the held values and have no side effect. Reading an address again returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_chan | input | 1 | 1 turns channel 1 off |
| ev_ce | input | NCH | Correctable event, one bit per channel |
| ev_ue | input | NCH | Uncorrectable event, one bit per channel |
| ev_col | input | NCH*16 | Column of the event, per channel |
| ev_row | input | NCH*16 | Row of the event, per channel |
| ev_bank | input | NCH*3 | Bank of the event, per channel |
| ev_rank | input | NCH*2 | Rank of the event, per channel |
| ev_synd | input | NCH*8 | Syndrome of the event, per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The directed patterns follow one log through its full life: correctable capture, a repeated correctable event, an uncorrectable takeover, and ignored later events. Clearing with zero data and writing to other addresses show that nothing changes unless a one is written to the status word. A clear that lands in the same cycle as an event separates "event wins" from "clear wins". Toggling the channel-off input, with events arriving on both channels, separates the two channels' gating. Long random runs then mix events, clears and reads, so that the capture priority and the row index are checked against many field values.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYND_W = 8;
  localparam int LOG_W  = 64;
  localparam int BUS_W  = 32;
  localparam int STAT_W = 16;
  localparam int RANKS_PER_CH = 1 << RANK_W;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYND_W-1:0] synd;
  } err_info_t;

  // Field positions are fixed by the software-visible log layout.
  function automatic logic [LOG_W-1:0] pack_log(err_info_t i, logic ue, logic ce);
    return {i.col, i.row, i.bank, i.rank, 3'b000, i.synd, 14'h0000, ue, ce};
  endfunction
endpackage

// File: rtl/ecc_status_reg.sv
module ecc_status_reg
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_ce,
  input  logic              set_ue,
  input  logic              clr_ce,
  input  logic              clr_ue,
  output logic [STAT_W-1:0] status
);
  logic st_ce, st_ue;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_ce <= 1'b0;
      st_ue <= 1'b0;
    end else begin
      // a new event outranks a clear arriving in the same cycle
      st_ce <= (st_ce & ~clr_ce) | set_ce;
      st_ue <= (st_ue & ~clr_ue) | set_ue;
    end
  end

  assign status = {{(STAT_W-2){1'b0}}, st_ue, st_ce};

  a_r2_clear_ce: assert property (@(posedge clk) disable iff (rst)
    (clr_ce && !set_ce) |=> !status[0]);
  a_r2_clear_ue: assert property (@(posedge clk) disable iff (rst)
    (clr_ue && !set_ue) |=> !status[1]);
  a_r7_event_wins_ce: assert property (@(posedge clk) disable iff (rst)
    set_ce |=> status[0]);
  a_r7_event_wins_ue: assert property (@(posedge clk) disable iff (rst)
    set_ue |=> status[1]);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_ce && !clr_ue && !set_ce && !set_ue) |=> $stable(status));
endmodule

// File: rtl/ecc_chan_log.sv
module ecc_chan_log
  import ecc_cap_pkg::*;
#(
  parameter int CH_IDX   = 0,
  parameter int ROWIDX_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                ev_ce,
  input  logic                ev_ue,
  input  err_info_t           info,
  input  logic                clr_ce,
  input  logic                clr_ue,
  output logic [LOG_W-1:0]    log_q,
  output logic [ROWIDX_W-1:0] row_idx
);
  logic      held_ce, held_ue;
  err_info_t info_q;
  logic      keep_ce, keep_ue, n_ce, n_ue;
  err_info_t n_info;

  always_comb begin
    keep_ce = held_ce & ~clr_ce;
    keep_ue = held_ue & ~clr_ue;
    n_ce    = keep_ce;
    n_ue    = keep_ue;
    n_info  = (keep_ce | keep_ue) ? info_q : '0;
    if (ev_ue && !keep_ue) begin
      n_ue   = 1'b1;
      n_ce   = 1'b0;
      n_info = info;
    end else if (ev_ce && !keep_ce && !keep_ue) begin
      n_ce   = 1'b1;
      n_info = info;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      held_ce <= 1'b0;
      held_ue <= 1'b0;
      info_q  <= '0;
    end else begin
      held_ce <= n_ce;
      held_ue <= n_ue;
      info_q  <= n_info;
    end
  end

  assign log_q   = pack_log(info_q, held_ue, held_ce);
  assign row_idx = ROWIDX_W'(info_q.rank) | ROWIDX_W'(CH_IDX * RANKS_PER_CH);

  a_r5_ue_capture: assert property (@(posedge clk) disable iff (rst)
    (en && ev_ue) |=> (!en || (log_q[1] && !log_q[0])));
  a_r5_ue_sticky: assert property (@(posedge clk) disable iff (rst)
    (en && log_q[1] && !clr_ue) |=> (!en || $stable(log_q)));
  a_r4_ce_first: assert property (@(posedge clk) disable iff (rst)
    (en && log_q[0] && !clr_ce && !ev_ue) |=> (!en || $stable(log_q)));
  a_r8_off_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> (log_q == '0));
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (log_q[1:0] == 2'b00) |-> (log_q == '0));
endmodule

// File: rtl/ecc_reg_read.sv
module ecc_reg_read
  import ecc_cap_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int ADDR_W   = 4,
  parameter int ROWIDX_W = 3
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [STAT_W-1:0]       status,
  input  logic [NCH*LOG_W-1:0]    logs,
  input  logic [NCH*ROWIDX_W-1:0] rows,
  output logic [BUS_W-1:0]        rdata
);
  localparam int ROW_BASE = 1 + 2 * NCH;

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = BUS_W'(status);
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(1 + 2 * c)) rdata = logs[c*LOG_W +: BUS_W];
      if (addr == ADDR_W'(2 + 2 * c)) rdata = logs[c*LOG_W + BUS_W +: BUS_W];
      if (addr == ADDR_W'(ROW_BASE + c)) rdata = BUS_W'(rows[c*ROWIDX_W +: ROWIDX_W]);
    end
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  single_chan,
  input  logic [NCH-1:0]        ev_ce,
  input  logic [NCH-1:0]        ev_ue,
  input  logic [NCH*COL_W-1:0]  ev_col,
  input  logic [NCH*ROW_W-1:0]  ev_row,
  input  logic [NCH*BANK_W-1:0] ev_bank,
  input  logic [NCH*RANK_W-1:0] ev_rank,
  input  logic [NCH*SYND_W-1:0] ev_synd,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [BUS_W-1:0]      reg_wdata,
  output logic [BUS_W-1:0]      reg_rdata
);
  localparam int ROWIDX_W = $clog2(NCH * RANKS_PER_CH);

  logic                    wr_status, clr_ce, clr_ue, set_ce, set_ue;
  logic [NCH-1:0]          ch_en;
  logic [STAT_W-1:0]       status;
  logic [NCH*LOG_W-1:0]    logs;
  logic [NCH*ROWIDX_W-1:0] rows;

  assign wr_status = reg_wr && (reg_addr == '0);
  assign clr_ce    = wr_status & reg_wdata[0];
  assign clr_ue    = wr_status & reg_wdata[1];
  assign set_ce    = |(ev_ce & ch_en);
  assign set_ue    = |(ev_ue & ch_en);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    err_info_t info;
    if (c == 0) begin : g_main
      assign ch_en[c] = 1'b1;
    end else begin : g_opt
      assign ch_en[c] = !single_chan;
    end
    assign info.col  = ev_col [c*COL_W  +: COL_W];
    assign info.row  = ev_row [c*ROW_W  +: ROW_W];
    assign info.bank = ev_bank[c*BANK_W +: BANK_W];
    assign info.rank = ev_rank[c*RANK_W +: RANK_W];
    assign info.synd = ev_synd[c*SYND_W +: SYND_W];

    ecc_chan_log #(.CH_IDX(c), .ROWIDX_W(ROWIDX_W)) i_log (
      .clk(clk), .rst(rst), .en(ch_en[c]),
      .ev_ce(ev_ce[c]), .ev_ue(ev_ue[c]), .info(info),
      .clr_ce(clr_ce), .clr_ue(clr_ue),
      .log_q(logs[c*LOG_W +: LOG_W]),
      .row_idx(rows[c*ROWIDX_W +: ROWIDX_W])
    );
  end

  ecc_status_reg i_status (
    .clk(clk), .rst(rst), .set_ce(set_ce), .set_ue(set_ue),
    .clr_ce(clr_ce), .clr_ue(clr_ue), .status(status)
  );

  ecc_reg_read #(.NCH(NCH), .ADDR_W(ADDR_W), .ROWIDX_W(ROWIDX_W)) i_read (
    .addr(reg_addr), .status(status), .logs(logs), .rows(rows), .rdata(reg_rdata)
  );

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == '0) |-> (reg_rdata[BUS_W-1:2] == '0));
  a_r8_ch1_no_status: assert property (@(posedge clk) disable iff (rst)
    (single_chan && !ev_ce[0] && !clr_ce && !status[0]) |=> !status[0]);
  a_r10_read_stable: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && $past(!reg_wr) && $stable(reg_addr) && ev_ce == '0 && ev_ue == '0
     && $past(ev_ce == '0) && $past(ev_ue == '0) && $stable(single_chan))
    |-> $stable(reg_rdata));
endmodule

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           single_chan = 1'b0;
  logic [1:0]     ev_ce = '0, ev_ue = '0;
  logic [31:0]    ev_col = '0, ev_row = '0;
  logic [5:0]     ev_bank = '0;
  logic [3:0]     ev_rank = '0;
  logic [15:0]    ev_synd = '0;
  logic           reg_wr = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_log [2];
  logic [1:0]  m_st;

  ecc_err_capture #(.NCH(NCH), .ADDR_W(4)) i_ecc_err_capture (
    .clk(clk), .rst(rst), .single_chan(single_chan),
    .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_col(ev_col), .ev_row(ev_row),
    .ev_bank(ev_bank), .ev_rank(ev_rank), .ev_synd(ev_synd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] mk(int c, logic ue, logic ce);
    return {ev_col[c*16 +: 16], ev_row[c*16 +: 16], ev_bank[c*3 +: 3], ev_rank[c*2 +: 2],
            3'b000, ev_synd[c*8 +: 8], 14'h0, ue, ce};
  endfunction

  function automatic logic [31:0] exp_read(int a);
    case (a)
      0: return {30'h0, m_st};
      1: return m_log[0][31:0];
      2: return m_log[0][63:32];
      3: return m_log[1][31:0];
      4: return m_log[1][63:32];
      5: return {30'h0, m_log[0][28:27]};
      6: return 32'd4 | {30'h0, m_log[1][28:27]};
      default: return 32'h0;
    endcase
  endfunction

  // Expected state after one clock with the currently driven inputs.
  task automatic model_update();
    logic [1:0] clr;
    logic [1:0] s;
    clr = (reg_wr && reg_addr == 4'd0) ? reg_wdata[1:0] : 2'b00;
    s = m_st & ~clr;
    for (int c = 0; c < NCH; c++) begin
      logic [63:0] l;
      if (c == 1 && single_chan) begin
        m_log[c] = '0;
        continue;
      end
      s = s | {ev_ue[c], ev_ce[c]};
      l = m_log[c];
      if (clr[0]) l[0] = 1'b0;
      if (clr[1]) l[1] = 1'b0;
      if (l[1:0] == 2'b00) l = '0;
      if (ev_ue[c] && !l[1]) l = mk(c, 1'b1, 1'b0);
      else if (ev_ce[c] && l[1:0] == 2'b00) l = mk(c, 1'b0, 1'b1);
      m_log[c] = l;
    end
    m_st = s;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [1:0] ce, input logic [1:0] ue, input logic wr,
                      input logic [3:0] wa, input logic [31:0] wd);
    ev_ce = ce; ev_ue = ue; reg_wr = wr; reg_addr = wa; reg_wdata = wd;
    ev_col = $urandom; ev_row = $urandom; ev_bank = 6'($urandom);
    ev_rank = 4'($urandom); ev_synd = 16'($urandom);
    model_update();
    @(negedge clk);
    ev_ce = '0; ev_ue = '0; reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] e;
    reg_addr = 4'(a);
    #1;
    e = exp_read(a);
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, e);
    end
    @(negedge clk);
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 9; a++) rd(a, tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    m_log[0] = '0; m_log[1] = '0; m_st = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd_all("R1");                                   // reset state
    step(2'b01, 2'b00, 0, 0, 0);  rd_all("R4");     // CE capture ch0
    step(2'b01, 2'b00, 0, 0, 0);  rd_all("R4");     // second CE ignored
    step(2'b00, 2'b01, 0, 0, 0);  rd_all("R5");     // UE replaces CE
    step(2'b01, 2'b00, 0, 0, 0);  rd_all("R5");     // CE after UE ignored
    step(2'b00, 2'b01, 0, 0, 0);  rd_all("R5");     // UE after UE ignored
    step(2'b00, 2'b00, 1, 0, 32'hFFFF_FFFC); rd_all("R2");   // zeros clear nothing
    step(2'b00, 2'b00, 1, 1, 32'h3);          rd_all("R2");   // other address
    step(2'b00, 2'b00, 1, 0, 32'h2);          rd_all("R6");   // release UE
    step(2'b10, 2'b00, 0, 0, 0);              rd_all("R4");   // ch1 CE
    step(2'b11, 2'b00, 1, 0, 32'h1);          rd_all("R7");   // clear + event
    step(2'b00, 2'b11, 1, 0, 32'h2);          rd_all("R7");
    step(2'b00, 2'b00, 1, 0, 32'h3);          rd_all("R6");
    single_chan = 1'b1;
    step(2'b10, 2'b10, 0, 0, 0);              rd_all("R8");   // ch1 ignored
    single_chan = 1'b0;
    step(2'b10, 2'b00, 0, 0, 0);              rd_all("R8");   // ch1 live again
    step(2'b00, 2'b00, 1, 0, 32'h3);          rd_all("R10");
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      wr = ($urandom % 4) == 0;
      if (($urandom % 64) == 0) single_chan = ~single_chan;
      step(2'(($urandom % 4 == 0) ? $urandom : 0), 2'(($urandom % 6 == 0) ? $urandom : 0),
           wr, 4'(wr ? (($urandom % 2) ? 0 : $urandom % 9) : 0), $urandom);
      begin
        int a;
        a = $urandom % 9;
        rd(a, (a >= 5 && a <= 6) ? "R9" : (a == 0 ? "R1" : "R3"));
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule